// File: doc/BRIEF.md
# Burst SRAM Address and Cycle Controller

This block is the clocked front end of a synchronous burst static RAM. On every rising clock edge it looks at the chip selects, two active-low address strobes, the advance input, the burst-order select and the write controls. From these it classifies the cycle as idle (deselected), burst start, burst step or burst hold. It registers the cycle direction and a four-lane byte write mask. It also keeps the array address, whose two low bits run through a small burst counter.

The first strobe, `procStrobeN`, has priority and always starts a read. It is masked when `chipEn1N` is high. The second strobe, `ctrlStrobeN`, starts a read or a write as the write controls dictate. The burst order is linear (counting up, modulo 4) or interleaved (loaded low bits XOR the beat count). The order is latched when a burst starts. All outputs are registered, so they show the cycle decided at the most recent clock edge.

Top module: `burst_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `cycleActive`=0, `cycleKind`=0 (idle), `cycleWrite`=0, `writeMask`=0 and `arrayAddr`=0.
- R2: A cycle is a start when `ctrlStrobeN` is low, or when `procStrobeN` is low with `chipEn1N` low. If the device is selected on that edge, the next outputs show `cycleKind`=1 (start), `cycleActive`=1 and `arrayAddr` equal to `addrIn`.
- R3: With `orderSel`=0 (linear), each step cycle (no strobe, `advanceN` low) adds 1 modulo 4 to the low two address bits, counting from the loaded value. The fifth access of a burst returns to the loaded address. `cycleKind`=2 on a step.
- R4: With `orderSel`=1 (interleaved), the low two bits of successive accesses are the loaded bits XOR 0, 1, 2, 3, then back to XOR 0 on the fifth access.
- R5: With no strobe, an active burst and `advanceN` high, the address is held and `cycleKind`=3 (hold).
- R6: `procStrobeN` has no effect while `chipEn1N` is high. An active burst then steps or holds as if no strobe were present.
- R7: On a start cycle, if the selects are false (`chipEn1N` high, `chipEn2` low or `chipEn3N` high), the cycle is a deselect: `cycleActive`=0, `cycleKind`=0, `writeMask`=0. On cycles with no strobe, `chipEn2` and `chipEn3N` are ignored.
- R8: A burst started by `procStrobeN` (with `chipEn1N` low) is a read with `writeMask`=0, whatever the write controls and `ctrlStrobeN` are.
- R9: For a burst started by `ctrlStrobeN` alone, the mask works as follows. `globalWrN` low gives `writeMask`=4'hF. Otherwise `byteWrN` low gives `writeMask[i]` = NOT `byteEnN[i]`. Otherwise the mask is 0. `cycleWrite` is 1 exactly when the mask is non-zero.
- R10: A new address can be loaded on consecutive edges; each start shows its own address on the next cycle.
- R11: Address bits above bit 1 change only on a start cycle or a reset.
- R12: With no strobe and no active burst, the block stays idle and the address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chipEn1N | input | 1 | Select 1, active low; also masks `procStrobeN` |
| chipEn2 | input | 1 | Select 2, active high, sampled only on start cycles |
| chipEn3N | input | 1 | Select 3, active low, sampled only on start cycles |
| procStrobeN | input | 1 | Priority address strobe, active low, read only |
| ctrlStrobeN | input | 1 | Second address strobe, active low, read or write |
| advanceN | input | 1 | Burst advance, active low |
| orderSel | input | 1 | 0 linear, 1 interleaved burst order |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Lane write qualifier, active low |
| byteEnN | input | 4 | Per-lane enables, active low |
| addrIn | input | ADDR_W | External address |
| arrayAddr | output | ADDR_W | Address presented to the array |
| cycleActive | output | 1 | A burst cycle is in progress |
| cycleWrite | output | 1 | Current cycle writes |
| writeMask | output | 4 | Lanes written in the current cycle |
| cycleKind | output | 2 | 0 idle, 1 start, 2 step, 3 hold |

## Verification
The assertions assume that every control input is a known 0 or 1 at each clock edge. They also assume that reset is held for at least one edge before the first checked cycle. The bench drives all inputs only at the falling edge, from a vector table and from directed tasks, so every input is defined and stable across each rising edge. The bench also asserts reset before any stimulus and again in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_START = 2'd1,
    KIND_STEP  = 2'd2,
    KIND_HOLD  = 2'd3
  } cycle_kind_e;

  typedef struct packed {
    logic load;
    logic step;
  } addr_strobe_t;

  function automatic logic [LANES-1:0] laneMask(
    input logic             globalWrN,
    input logic             byteWrN,
    input logic [LANES-1:0] byteEnN
  );
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!globalWrN)    m[i] = 1'b1;
      else if (!byteWrN) m[i] = ~byteEnN[i];
    end
    return m;
  endfunction

endpackage

// File: rtl/burst_seq_control.sv
module burst_seq_control
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chipEn1N,
  input  logic             chipEn2,
  input  logic             chipEn3N,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             globalWrN,
  input  logic             byteWrN,
  input  logic [LANES-1:0] byteEnN,
  output addr_strobe_t     addrCmd,
  output logic             cycleActive,
  output logic             cycleWrite,
  output logic [LANES-1:0] writeMask,
  output logic [1:0]       cycleKind
);

  logic             procHit, startHit, selOk;
  logic             activeQ, activeD;
  logic [LANES-1:0] maskQ, maskD;
  cycle_kind_e      kindQ, kindD;

  assign procHit  = !procStrobeN && !chipEn1N;
  assign startHit = procHit || !ctrlStrobeN;
  assign selOk    = !chipEn1N && chipEn2 && !chipEn3N;

  always_comb begin
    activeD = activeQ;
    maskD   = maskQ;
    kindD   = KIND_IDLE;
    addrCmd = '0;
    if (startHit) begin
      if (selOk) begin
        activeD      = 1'b1;
        kindD        = KIND_START;
        addrCmd.load = 1'b1;
        maskD        = procHit ? '0 : laneMask(globalWrN, byteWrN, byteEnN);
      end else begin
        activeD = 1'b0;
        maskD   = '0;
      end
    end else if (activeQ) begin
      if (!advanceN) begin
        kindD        = KIND_STEP;
        addrCmd.step = 1'b1;
      end else begin
        kindD = KIND_HOLD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
      maskQ   <= '0;
      kindQ   <= KIND_IDLE;
    end else begin
      activeQ <= activeD;
      maskQ   <= maskD;
      kindQ   <= kindD;
    end
  end

  assign cycleActive = activeQ;
  assign writeMask   = maskQ;
  assign cycleWrite  = |maskQ;
  assign cycleKind   = kindQ;

endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_strobe_t      addrCmd,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr
);

  localparam int CNT_W = 2;
  localparam int UP_W  = ADDR_W - CNT_W;

  logic [UP_W-1:0]  upperQ;
  logic [CNT_W-1:0] baseQ, cntQ, lowBits;
  logic             orderQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      upperQ <= '0;
      baseQ  <= '0;
      cntQ   <= '0;
      orderQ <= 1'b1;
    end else if (addrCmd.load) begin
      upperQ <= addrIn[ADDR_W-1:CNT_W];
      baseQ  <= addrIn[CNT_W-1:0];
      cntQ   <= '0;
      orderQ <= orderSel;
    end else if (addrCmd.step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign lowBits   = orderQ ? (baseQ ^ cntQ) : (baseQ + cntQ);
  assign arrayAddr = {upperQ, lowBits};

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [3:0]        byteEnN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              cycleActive,
  output logic              cycleWrite,
  output logic [3:0]        writeMask,
  output logic [1:0]        cycleKind
);

  addr_strobe_t addrCmd;

  burst_seq_control i_control (
    .clk         (clk),
    .rst         (rst),
    .chipEn1N    (chipEn1N),
    .chipEn2     (chipEn2),
    .chipEn3N    (chipEn3N),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .globalWrN   (globalWrN),
    .byteWrN     (byteWrN),
    .byteEnN     (byteEnN),
    .addrCmd     (addrCmd),
    .cycleActive (cycleActive),
    .cycleWrite  (cycleWrite),
    .writeMask   (writeMask),
    .cycleKind   (cycleKind)
  );

  burst_seq_addr #(.ADDR_W(ADDR_W)) i_addr (
    .clk       (clk),
    .rst       (rst),
    .addrCmd   (addrCmd),
    .orderSel  (orderSel),
    .addrIn    (addrIn),
    .arrayAddr (arrayAddr)
  );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              chipEn1N,
  input logic              chipEn2,
  input logic              chipEn3N,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] arrayAddr,
  input logic              cycleActive,
  input logic              cycleWrite,
  input logic [3:0]        writeMask,
  input logic [1:0]        cycleKind
);

  logic startIn, selIn, procIn;
  assign procIn  = !procStrobeN && !chipEn1N;
  assign startIn = procIn || !ctrlStrobeN;
  assign selIn   = !chipEn1N && chipEn2 && !chipEn3N;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!cycleActive && cycleKind == 2'd0 && writeMask == 4'd0)); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (startIn && selIn) |=> (cycleKind == 2'd1 && cycleActive && arrayAddr == $past(addrIn))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!startIn && cycleActive && advanceN) |=> ($stable(arrayAddr) && cycleKind == 2'd3)); // R5

  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (startIn && !selIn) |=> (!cycleActive && writeMask == 4'd0)); // R7

  AST_PROC_READ: assert property (@(posedge clk) disable iff (rst)
    (procIn && selIn) |=> !cycleWrite); // R8

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    !startIn |=> $stable(arrayAddr[ADDR_W-1:2])); // R11

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!startIn && !cycleActive) |=> (!cycleActive && cycleKind == 2'd0)); // R12

endmodule

bind burst_seq_ctrl burst_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .chipEn1N    (chipEn1N),
  .chipEn2     (chipEn2),
  .chipEn3N    (chipEn3N),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .advanceN    (advanceN),
  .addrIn      (addrIn),
  .arrayAddr   (arrayAddr),
  .cycleActive (cycleActive),
  .cycleWrite  (cycleWrite),
  .writeMask   (writeMask),
  .cycleKind   (cycleKind)
);

// File: tb/test_burst_seq_ctrl.sv
module test_burst_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  typedef struct packed {
    logic          e1n, e2, e3n, pN, cN, aN, ord, gwN, bwN;
    logic [3:0]    ben;
    logic [AW-1:0] addr;
    logic          act, wr;
    logic [3:0]    mask;
    logic [1:0]    kind;
    logic [AW-1:0] eaddr;
    logic [7:0]    tag;
  } vec_t;

  localparam int NV = 21;
  // order: e1n e2 e3n pN cN aN ord gwN bwN ben addr | act wr mask kind eaddr tag
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,18'h00105, 1'b1,1'b0,4'h0,2'd1,18'h00105,8'd2},  // R2 start linear
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h00106,8'd3},  // R3
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h00107,8'd3},  // R3
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h00104,8'd3},  // R3 modulo
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h00105,8'd3},  // R3 fifth wraps
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd3,18'h00105,8'd5},  // R5 hold
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,18'h0002A, 1'b1,1'b0,4'h0,2'd1,18'h0002A,8'd8},  // R8 proc read
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h0002B,8'd4},  // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h00028,8'd4},  // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h00029,8'd4},  // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b0,4'h0,2'd2,18'h0002A,8'd4},  // R4 wrap
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h3FFFF, 1'b1,1'b0,4'h0,2'd2,18'h0002B,8'd6},  // R6 masked strobe
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'hF,18'h11111, 1'b0,1'b0,4'h0,2'd0,18'h0002B,8'd7},  // R7 deselect
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,18'h22222, 1'b0,1'b0,4'h0,2'd0,18'h0002B,8'd12}, // R12 idle
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,18'h3C003, 1'b1,1'b1,4'hF,2'd1,18'h3C003,8'd9},  // R9 global
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,18'h0,     1'b1,1'b1,4'hF,2'd2,18'h3C000,8'd11}, // R11 R7 selects ignored
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'hA,18'h00010, 1'b1,1'b1,4'h5,2'd1,18'h00010,8'd9},  // R9 lanes
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'hF,18'h00011, 1'b1,1'b0,4'h0,2'd1,18'h00011,8'd10}, // R10 R9 no lanes
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'h0,18'h00012, 1'b1,1'b0,4'h0,2'd1,18'h00012,8'd10}, // R10 read
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0,18'h00013, 1'b1,1'b0,4'h0,2'd1,18'h00013,8'd8},  // R8 priority
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,18'h00020, 1'b0,1'b0,4'h0,2'd0,18'h00013,8'd7}   // R7 chipEn1N high
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          chipEn1N, chipEn2, chipEn3N, procStrobeN, ctrlStrobeN, advanceN;
  logic          orderSel, globalWrN, byteWrN;
  logic [3:0]    byteEnN;
  logic [AW-1:0] addrIn, arrayAddr;
  logic          cycleActive, cycleWrite;
  logic [3:0]    writeMask;
  logic [1:0]    cycleKind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq_ctrl #(.ADDR_W(AW)) i_burst_seq_ctrl (
    .clk(clk), .rst(rst), .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .orderSel(orderSel), .globalWrN(globalWrN), .byteWrN(byteWrN), .byteEnN(byteEnN),
    .addrIn(addrIn), .arrayAddr(arrayAddr), .cycleActive(cycleActive),
    .cycleWrite(cycleWrite), .writeMask(writeMask), .cycleKind(cycleKind)
  );

  task automatic drive(input vec_t v);
    chipEn1N = v.e1n; chipEn2 = v.e2; chipEn3N = v.e3n;
    procStrobeN = v.pN; ctrlStrobeN = v.cN; advanceN = v.aN;
    orderSel = v.ord; globalWrN = v.gwN; byteWrN = v.bwN;
    byteEnN = v.ben; addrIn = v.addr;
  endtask

  task automatic expect_out(input logic act, input logic wr, input logic [3:0] mask,
                            input logic [1:0] kind, input logic [AW-1:0] ea, input int tag);
    checks++;
    if (cycleActive !== act || cycleWrite !== wr || writeMask !== mask ||
        cycleKind !== kind || arrayAddr !== ea) begin
      errors++;
      $display("FAIL R%0d: act/wr/mask/kind/addr got %b/%b/%h/%0d/%h expected %b/%b/%h/%0d/%h",
               tag, cycleActive, cycleWrite, writeMask, cycleKind, arrayAddr,
               act, wr, mask, kind, ea);
    end
  endtask

  task automatic idleInputs();
    chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0;
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    orderSel = 1'b0; globalWrN = 1'b1; byteWrN = 1'b1; byteEnN = 4'hF; addrIn = '0;
  endtask

  initial begin
    rst = 1'b1;
    idleInputs();
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_out(1'b0, 1'b0, 4'h0, 2'd0, 18'h0, 1); // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      expect_out(VEC[i].act, VEC[i].wr, VEC[i].mask, VEC[i].kind, VEC[i].eaddr, int'(VEC[i].tag));
    end
    // R1: reset in the middle of a write burst
    idleInputs();
    ctrlStrobeN = 1'b0; globalWrN = 1'b0; addrIn = 18'h2F0F2;
    @(posedge clk); @(negedge clk);
    ctrlStrobeN = 1'b1; advanceN = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out(1'b0, 1'b0, 4'h0, 2'd0, 18'h0, 1); // R1
    rst = 1'b0;
    // R12: after reset, stepping with no strobe keeps idle
    @(posedge clk); @(negedge clk);
    expect_out(1'b0, 1'b0, 4'h0, 2'd0, 18'h0, 12); // R12
    // R4 R5: interleaved burst from low bits 11, step then hold
    idleInputs();
    ctrlStrobeN = 1'b0; orderSel = 1'b1; addrIn = 18'h00403;
    @(posedge clk); @(negedge clk);
    ctrlStrobeN = 1'b1; orderSel = 1'b0; advanceN = 1'b0;
    @(posedge clk); @(negedge clk);
    expect_out(1'b1, 1'b0, 4'h0, 2'd2, 18'h00402, 4); // R4 order latched at start
    advanceN = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out(1'b1, 1'b0, 4'h0, 2'd3, 18'h00402, 5); // R5
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule